// File: doc/BRIEF.md
# PLL Power-Up Bring-Up Sequencer

This block is a hardware state machine that takes a PLL from power-down to driving the system clock. It drives five control lines. The first is an internal-source override for the bypass control. The second is the PLL enable, where 0 means bypass and 1 means the PLL output is used. The other three are PLL reset, PLL output disable and PLL power-down. It also presents a new multiplier value with a one-cycle load strobe. When asked, it loads a new divider ratio and runs a go / busy handshake with the divider phase-alignment logic. Every wait in the sequence is timed by one down-counter that runs on the reference clock.

A single-cycle `start` launches a run. The multiplier, the ratio and the update flag are captured at that moment, so changes on those inputs during the run have no effect. The run follows a fixed order of steps:

1. Release the override and select bypass.
2. Wait, then assert reset and disable the PLL output.
3. Power up the PLL and re-enable its output.
4. Wait for stabilisation, then load the multiplier. The optional divider update and the minimum reset-hold timer run side by side at this point.
5. Release reset and wait for lock.
6. Leave bypass and pulse `done`.

Top module: `pll_bringup_seq`

## Requirements
- R1: In reset and after it, until a start is taken, the outputs read: `src_ovr`=1, `pll_pwrdn`=1, `pll_en`=0, `pll_rst`=0, `pll_outdis`=0, and `mult_ld`, `ratio_ld`, `div_go` and `done` all 0.
- R2: A start sampled at clock edge 0 clears `src_ovr` at edge 1. At edge 2 it drives `pll_en` to 0 (bypass).
- R3: `pll_rst` rises exactly BYP_WAIT (20) reference cycles after bypass is selected, at edge 22.
- R4: `pll_outdis` rises at edge 23. `pll_pwrdn` falls at edge 24. `pll_outdis` falls at edge 25.
- R5: `mult_ld` is high for exactly one cycle, STAB_WAIT (4096) cycles after the output is re-enabled, at edge 4121. In that cycle `mult_val` equals the multiplier captured at start, `pll_en` is 0 and `pll_rst` is 1.
- R6: When the captured update flag is 1, `ratio_ld` pulses in the same cycle as `mult_ld`, with `ratio_val` equal to the captured ratio. `div_go` then pulses for one cycle at the next edge. When the flag is 0, neither strobe pulses.
- R7: Let M be the `mult_ld` edge. `pll_rst` falls at edge max(M+RST_MIN, E+1), where RST_MIN is 32. When no update is requested, only the first term applies. E is the first edge at or after M+3 at which `div_busy` is sampled low.
- R8: `pll_en` rises exactly LOCK_WAIT (2000) cycles after `pll_rst` falls. At that moment reset, power-down and output disable are all low.
- R9: `done` is high for exactly one cycle, at the edge after `pll_en` rises.
- R10: A start that arrives while a run is in progress is ignored. It neither restarts nor extends the run, and it does not cause a second run afterwards. Input changes after the start do not alter `mult_val` or `ratio_val`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the sequence |
| mult_tgt | input | MULT_W | Multiplier to load |
| ratio_tgt | input | RATIO_W | Divider ratio to load |
| ratio_upd | input | 1 | 1 = perform the divider update |
| div_busy | input | 1 | Divider phase alignment in progress |
| src_ovr | output | 1 | 1 = bypass control taken from the internal source |
| pll_en | output | 1 | 0 = bypass, 1 = PLL clock selected |
| pll_rst | output | 1 | PLL reset |
| pll_outdis | output | 1 | PLL output disable |
| pll_pwrdn | output | 1 | PLL power-down |
| mult_val | output | MULT_W | Multiplier value presented to the PLL |
| mult_ld | output | 1 | One-cycle multiplier load strobe |
| ratio_val | output | RATIO_W | Ratio value presented to the divider |
| ratio_ld | output | 1 | One-cycle ratio load strobe |
| div_go | output | 1 | One-cycle divider transition request |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench measures the edge of every control transition relative to the accepted start, and compares it against offsets derived from the four wait lengths. An off-by-one reload of the shared counter shifts every later event by a cycle. The reset-release step is run three ways:

- with the divider busy for longer than the 32-cycle hold, where a design that ignored the handshake would release reset early;
- with the busy time shorter than the hold, where a design that waited for the handshake alone would release reset too soon;
- with no update, where a design that still waited for a busy drop, or still pulsed the strobes, would be caught.

Extra starts and input changes are injected mid-run. A sequencer that latched them would restart, shift its timing, run a second time after `done`, or load the wrong values. One run is chained straight after another without reset, to show that bypass is re-selected at edge 2.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

   typedef enum logic [3:0] {
      SQ_IDLE,
      SQ_CLR_SRC,
      SQ_SEL_BYP,
      SQ_WAIT_BYP,
      SQ_DIS_OUT,
      SQ_PWR_UP,
      SQ_EN_OUT,
      SQ_WAIT_STAB,
      SQ_RST_HOLD,
      SQ_WAIT_LOCK,
      SQ_FINISH
   } seq_state_e;

   typedef enum logic [2:0] {
      HS_IDLE,
      HS_LOAD,
      HS_GO,
      HS_WAIT,
      HS_DONE
   } hs_state_e;

   function automatic int max_of4(input int a, input int b, input int c, input int d);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      if (d > m) m = d;
      return m;
   endfunction

endpackage

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             zero
);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= load_val;
      end else if (cnt != '0) begin
         cnt <= cnt - CNT_W'(1);
      end
   end

   assign zero = (cnt == '0);

   AST_CNT_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt == '0) |=> (cnt == '0)); // R7

   AST_CNT_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1))); // R3

endmodule

// File: rtl/pll_seq_divhs.sv
module pll_seq_divhs
   import pll_seq_pkg::*;
#(
   parameter int RATIO_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               kick,
   input  logic               clr,
   input  logic               upd_en,
   input  logic [RATIO_W-1:0] ratio_in,
   input  logic               div_busy,
   output logic [RATIO_W-1:0] ratio_val,
   output logic               ratio_ld,
   output logic               div_go,
   output logic               hs_done
);

   hs_state_e st;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= HS_IDLE;
         ratio_val <= '0;
         ratio_ld  <= 1'b0;
         div_go    <= 1'b0;
      end else begin
         ratio_ld <= 1'b0;
         div_go   <= 1'b0;
         case (st)
            HS_IDLE: begin
               if (kick) begin
                  if (upd_en) begin
                     ratio_val <= ratio_in;
                     ratio_ld  <= 1'b1;
                     st        <= HS_LOAD;
                  end else begin
                     st <= HS_DONE;
                  end
               end
            end
            HS_LOAD: begin
               div_go <= 1'b1;
               st     <= HS_GO;
            end
            HS_GO: begin
               st <= HS_WAIT;
            end
            HS_WAIT: begin
               if (!div_busy) st <= HS_DONE;
            end
            HS_DONE: begin
               if (clr) st <= HS_IDLE;
            end
            default: st <= HS_IDLE;
         endcase
      end
   end

   assign hs_done = (st == HS_DONE);

   AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      div_go |=> !div_go); // R6

   AST_GO_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      div_go |-> $past(ratio_ld)); // R6

   AST_RATIO_LD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_ld |=> !ratio_ld); // R6

endmodule

// File: rtl/pll_seq_ctl.sv
module pll_seq_ctl
   import pll_seq_pkg::*;
#(
   parameter int MULT_W    = 8,
   parameter int RATIO_W   = 5,
   parameter int CNT_W     = 12,
   parameter int BYP_WAIT  = 20,
   parameter int STAB_WAIT = 4096,
   parameter int RST_MIN   = 32,
   parameter int LOCK_WAIT = 2000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [MULT_W-1:0]  mult_tgt,
   input  logic [RATIO_W-1:0] ratio_tgt,
   input  logic               ratio_upd,
   input  logic               tmr_zero,
   input  logic               hs_done,
   output logic               tmr_load,
   output logic [CNT_W-1:0]   tmr_val,
   output logic               hs_kick,
   output logic               hs_clr,
   output logic [RATIO_W-1:0] ratio_q,
   output logic               upd_q,
   output logic               src_ovr,
   output logic               pll_en,
   output logic               pll_rst,
   output logic               pll_outdis,
   output logic               pll_pwrdn,
   output logic [MULT_W-1:0]  mult_val,
   output logic               mult_ld,
   output logic               done
);

   localparam logic [CNT_W-1:0] BYP_RLD  = CNT_W'(BYP_WAIT - 1);
   localparam logic [CNT_W-1:0] STAB_RLD = CNT_W'(STAB_WAIT - 1);
   localparam logic [CNT_W-1:0] RST_RLD  = CNT_W'(RST_MIN - 1);
   localparam logic [CNT_W-1:0] LOCK_RLD = CNT_W'(LOCK_WAIT - 1);

   seq_state_e       st;
   logic [MULT_W-1:0] mult_q;
   logic             stab_end;
   logic             hold_end;
   logic             lock_end;

   assign stab_end = (st == SQ_WAIT_STAB) && tmr_zero;
   assign hold_end = (st == SQ_RST_HOLD)  && tmr_zero && hs_done;
   assign lock_end = (st == SQ_WAIT_LOCK) && tmr_zero;

   // Counter reload points: one per wait, taken on entry to the wait
   always_comb begin
      tmr_load = 1'b0;
      tmr_val  = '0;
      if (st == SQ_SEL_BYP) begin
         tmr_load = 1'b1;
         tmr_val  = BYP_RLD;
      end else if (st == SQ_EN_OUT) begin
         tmr_load = 1'b1;
         tmr_val  = STAB_RLD;
      end else if (stab_end) begin
         tmr_load = 1'b1;
         tmr_val  = RST_RLD;
      end else if (hold_end) begin
         tmr_load = 1'b1;
         tmr_val  = LOCK_RLD;
      end
   end

   assign hs_kick = stab_end;
   assign hs_clr  = hold_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= SQ_IDLE;
         mult_q     <= '0;
         ratio_q    <= '0;
         upd_q      <= 1'b0;
         src_ovr    <= 1'b1;
         pll_en     <= 1'b0;
         pll_rst    <= 1'b0;
         pll_outdis <= 1'b0;
         pll_pwrdn  <= 1'b1;
         mult_val   <= '0;
         mult_ld    <= 1'b0;
         done       <= 1'b0;
      end else begin
         mult_ld <= 1'b0;
         done    <= 1'b0;
         case (st)
            SQ_IDLE: begin
               if (start) begin
                  mult_q  <= mult_tgt;
                  ratio_q <= ratio_tgt;
                  upd_q   <= ratio_upd;
                  st      <= SQ_CLR_SRC;
               end
            end
            SQ_CLR_SRC: begin
               src_ovr <= 1'b0;
               st      <= SQ_SEL_BYP;
            end
            SQ_SEL_BYP: begin
               pll_en <= 1'b0;
               st     <= SQ_WAIT_BYP;
            end
            SQ_WAIT_BYP: begin
               if (tmr_zero) begin
                  pll_rst <= 1'b1;
                  st      <= SQ_DIS_OUT;
               end
            end
            SQ_DIS_OUT: begin
               pll_outdis <= 1'b1;
               st         <= SQ_PWR_UP;
            end
            SQ_PWR_UP: begin
               pll_pwrdn <= 1'b0;
               st        <= SQ_EN_OUT;
            end
            SQ_EN_OUT: begin
               pll_outdis <= 1'b0;
               st         <= SQ_WAIT_STAB;
            end
            SQ_WAIT_STAB: begin
               if (tmr_zero) begin
                  mult_val <= mult_q;
                  mult_ld  <= 1'b1;
                  st       <= SQ_RST_HOLD;
               end
            end
            SQ_RST_HOLD: begin
               if (tmr_zero && hs_done) begin
                  pll_rst <= 1'b0;
                  st      <= SQ_WAIT_LOCK;
               end
            end
            SQ_WAIT_LOCK: begin
               if (tmr_zero) begin
                  pll_en <= 1'b1;
                  st     <= SQ_FINISH;
               end
            end
            SQ_FINISH: begin
               done <= 1'b1;
               st   <= SQ_IDLE;
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

   AST_LD_IN_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      mult_ld |-> (!pll_en && pll_rst)); // R5

   AST_RST_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pll_rst) |-> $past(hs_done)); // R7

   AST_EN_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pll_en) |-> (!pll_rst && !pll_pwrdn && !pll_outdis)); // R8

   AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R9

   AST_DONE_AFTER_EN: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pll_en && $past(pll_en))); // R9

endmodule

// File: rtl/pll_bringup_seq.sv
module pll_bringup_seq
   import pll_seq_pkg::*;
#(
   parameter int MULT_W      = 8,
   parameter int RATIO_W     = 5,
   parameter int BYP_WAIT    = 20,
   parameter int STAB_WAIT   = 4096,
   parameter int RST_MIN     = 32,
   parameter int LOCK_WAIT   = 2000,
   parameter bit DIV_SUPPORT = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [MULT_W-1:0]  mult_tgt,
   input  logic [RATIO_W-1:0] ratio_tgt,
   input  logic               ratio_upd,
   input  logic               div_busy,
   output logic               src_ovr,
   output logic               pll_en,
   output logic               pll_rst,
   output logic               pll_outdis,
   output logic               pll_pwrdn,
   output logic [MULT_W-1:0]  mult_val,
   output logic               mult_ld,
   output logic [RATIO_W-1:0] ratio_val,
   output logic               ratio_ld,
   output logic               div_go,
   output logic               done
);

   localparam int MAX_WAIT = max_of4(BYP_WAIT, STAB_WAIT, RST_MIN, LOCK_WAIT);
   localparam int CNT_W    = $clog2(MAX_WAIT + 1);

   if (MULT_W < 1 || RATIO_W < 1) begin : g_bad_width
      $error("pll_bringup_seq: value widths must be at least 1");
   end
   if (BYP_WAIT < 1 || STAB_WAIT < 1 || RST_MIN < 1 || LOCK_WAIT < 1) begin : g_bad_wait
      $error("pll_bringup_seq: every wait must be at least one cycle");
   end

   logic               tmr_load;
   logic [CNT_W-1:0]   tmr_val;
   logic               tmr_zero;
   logic               hs_kick;
   logic               hs_clr;
   logic               hs_done;
   logic [RATIO_W-1:0] ratio_q;
   logic               upd_q;

   pll_seq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .zero     (tmr_zero)
   );

   pll_seq_ctl #(
      .MULT_W    (MULT_W),
      .RATIO_W   (RATIO_W),
      .CNT_W     (CNT_W),
      .BYP_WAIT  (BYP_WAIT),
      .STAB_WAIT (STAB_WAIT),
      .RST_MIN   (RST_MIN),
      .LOCK_WAIT (LOCK_WAIT)
   ) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .mult_tgt   (mult_tgt),
      .ratio_tgt  (ratio_tgt),
      .ratio_upd  (ratio_upd),
      .tmr_zero   (tmr_zero),
      .hs_done    (hs_done),
      .tmr_load   (tmr_load),
      .tmr_val    (tmr_val),
      .hs_kick    (hs_kick),
      .hs_clr     (hs_clr),
      .ratio_q    (ratio_q),
      .upd_q      (upd_q),
      .src_ovr    (src_ovr),
      .pll_en     (pll_en),
      .pll_rst    (pll_rst),
      .pll_outdis (pll_outdis),
      .pll_pwrdn  (pll_pwrdn),
      .mult_val   (mult_val),
      .mult_ld    (mult_ld),
      .done       (done)
   );

   if (DIV_SUPPORT) begin : g_div
      pll_seq_divhs #(.RATIO_W(RATIO_W)) u_divhs (
         .clk       (clk),
         .rst_n     (rst_n),
         .kick      (hs_kick),
         .clr       (hs_clr),
         .upd_en    (upd_q),
         .ratio_in  (ratio_q),
         .div_busy  (div_busy),
         .ratio_val (ratio_val),
         .ratio_ld  (ratio_ld),
         .div_go    (div_go),
         .hs_done   (hs_done)
      );
   end else begin : g_nodiv
      assign ratio_val = '0;
      assign ratio_ld  = 1'b0;
      assign div_go    = 1'b0;
      assign hs_done   = 1'b1;
   end

   AST_STROBE_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_ld |-> mult_ld); // R6

endmodule

// File: tb/pll_bringup_seq_tb.sv
module pll_bringup_seq_tb_top;

   localparam int BYP  = 20;
   localparam int STAB = 4096;
   localparam int RMIN = 32;
   localparam int LOCK = 2000;

   typedef struct packed {
      logic [7:0] mult;
      logic [4:0] ratio;
      logic       upd;
      logic [7:0] busy_len;
      logic       poke;
      logic       chain;
   } vec_t;

   localparam int NVEC = 5;
   localparam vec_t VECS [NVEC] = '{
      '{mult: 8'h2A, ratio: 5'd3,  upd: 1'b1, busy_len: 8'd5,  poke: 1'b0, chain: 1'b0},
      '{mult: 8'h11, ratio: 5'd7,  upd: 1'b0, busy_len: 8'd0,  poke: 1'b1, chain: 1'b0},
      '{mult: 8'hFF, ratio: 5'd31, upd: 1'b1, busy_len: 8'd60, poke: 1'b0, chain: 1'b1},
      '{mult: 8'h01, ratio: 5'd0,  upd: 1'b1, busy_len: 8'd0,  poke: 1'b1, chain: 1'b0},
      '{mult: 8'h80, ratio: 5'd18, upd: 1'b1, busy_len: 8'd29, poke: 1'b0, chain: 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] mult_tgt = '0;
   logic [4:0] ratio_tgt = '0;
   logic       ratio_upd = 1'b0;
   logic       div_busy = 1'b0;
   logic       src_ovr, pll_en, pll_rst, pll_outdis, pll_pwrdn;
   logic [7:0] mult_val;
   logic       mult_ld;
   logic [4:0] ratio_val;
   logic       ratio_ld, div_go, done;

   int n_chk = 0;
   int n_bad = 0;
   int busy_len = 0;
   int busy_cnt = 0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   pll_bringup_seq dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .mult_tgt(mult_tgt),
      .ratio_tgt(ratio_tgt), .ratio_upd(ratio_upd), .div_busy(div_busy),
      .src_ovr(src_ovr), .pll_en(pll_en), .pll_rst(pll_rst),
      .pll_outdis(pll_outdis), .pll_pwrdn(pll_pwrdn), .mult_val(mult_val),
      .mult_ld(mult_ld), .ratio_val(ratio_val), .ratio_ld(ratio_ld),
      .div_go(div_go), .done(done)
   );

   // Divider model: busy for busy_len cycles after a go
   always @(negedge clk) begin
      if (!rst_n) busy_cnt = 0;
      else if (div_go) busy_cnt = busy_len;
      else if (busy_cnt > 0) busy_cnt = busy_cnt - 1;
      div_busy = (busy_cnt > 0);
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_reset_state();
      chk("R1 src_ovr", int'(src_ovr), 1);
      chk("R1 pll_pwrdn", int'(pll_pwrdn), 1);
      chk("R1 pll_en", int'(pll_en), 0);
      chk("R1 pll_rst", int'(pll_rst), 0);
      chk("R1 pll_outdis", int'(pll_outdis), 0);
      chk("R1 strobes", int'({mult_ld, ratio_ld, div_go, done}), 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check_reset_state();
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check_reset_state();
   endtask

   task automatic run_vec(input vec_t v);
      int cyc;
      int t_src = -1, t_byp = -1, t_rst_on = -1, t_od_on = -1, t_pwr = -1;
      int t_od_off = -1, t_mult = -1, t_ratio = -1, t_go = -1, t_rst_off = -1;
      int t_en = -1, t_done = -1;
      int n_mult = 0, n_ratio = 0, n_go = 0, n_done = 0;
      int m_seen = -1, r_seen = -1;
      int e_mult, e_busy, e_rel, e_en, e_done;
      bit prev_src, prev_en, prev_rst, prev_od, prev_pwr;
      e_mult = 5 + BYP + STAB;
      e_busy = (e_mult + 3 > e_mult + 2 + int'(v.busy_len)) ? e_mult + 3 : e_mult + 2 + int'(v.busy_len);
      e_rel  = e_mult + RMIN;
      if (v.upd && e_busy + 1 > e_rel) e_rel = e_busy + 1;
      e_en   = e_rel + LOCK;
      e_done = e_en + 1;
      busy_len = int'(v.busy_len);
      mult_tgt = v.mult; ratio_tgt = v.ratio; ratio_upd = v.upd; start = 1'b1;
      prev_src = src_ovr; prev_en = pll_en; prev_rst = pll_rst;
      prev_od = pll_outdis; prev_pwr = pll_pwrdn;
      @(negedge clk);
      start = 1'b0;
      cyc = 0;
      while (cyc <= e_done + 30) begin
         if (prev_src && !src_ovr && t_src < 0) t_src = cyc;
         if (prev_en && !pll_en && t_byp < 0) t_byp = cyc;
         if (!prev_rst && pll_rst && t_rst_on < 0) t_rst_on = cyc;
         if (!prev_od && pll_outdis && t_od_on < 0) t_od_on = cyc;
         if (prev_pwr && !pll_pwrdn && t_pwr < 0) t_pwr = cyc;
         if (prev_od && !pll_outdis && t_od_off < 0) t_od_off = cyc;
         if (prev_rst && !pll_rst && t_rst_off < 0) t_rst_off = cyc;
         if (!prev_en && pll_en && t_en < 0) t_en = cyc;
         if (mult_ld) begin n_mult++; if (t_mult < 0) begin t_mult = cyc; m_seen = int'(mult_val); end end
         if (ratio_ld) begin n_ratio++; if (t_ratio < 0) begin t_ratio = cyc; r_seen = int'(ratio_val); end end
         if (div_go) begin n_go++; if (t_go < 0) t_go = cyc; end
         if (done) begin n_done++; if (t_done < 0) t_done = cyc; end
         if (cyc > e_done && !pll_en)
            chk("R10 no rerun after done", 1, 0);
         prev_src = src_ovr; prev_en = pll_en; prev_rst = pll_rst;
         prev_od = pll_outdis; prev_pwr = pll_pwrdn;
         if (v.poke && cyc == 50)   begin start = 1'b1; mult_tgt = ~v.mult; ratio_tgt = ~v.ratio; ratio_upd = ~v.upd; end
         if (v.poke && cyc == 51)   start = 1'b0;
         if (v.poke && cyc == 4200) start = 1'b1;
         if (v.poke && cyc == 4201) start = 1'b0;
         @(negedge clk);
         cyc++;
      end
      if (v.chain) chk("R2 bypass reselected", t_byp, 2);
      else         chk("R2 override cleared", t_src, 1);
      chk("R3 reset asserted", t_rst_on, 2 + BYP);
      chk("R4 outdis set", t_od_on, 3 + BYP);
      if (!v.chain) chk("R4 powerdown cleared", t_pwr, 4 + BYP);
      chk("R4 outdis cleared", t_od_off, 5 + BYP);
      chk("R5 mult load edge", t_mult, e_mult);
      chk("R5 mult load count", n_mult, 1);
      chk("R10 mult value captured", m_seen, int'(v.mult));
      if (v.upd) begin
         chk("R6 ratio load edge", t_ratio, e_mult);
         chk("R10 ratio value captured", r_seen, int'(v.ratio));
         chk("R6 go edge", t_go, e_mult + 1);
         chk("R6 go count", n_go, 1);
      end else begin
         chk("R6 no ratio load", n_ratio, 0);
         chk("R6 no go", n_go, 0);
      end
      chk("R7 reset release edge", t_rst_off, e_rel);
      chk("R8 bypass left edge", t_en, e_en);
      chk("R9 done edge", t_done, e_done);
      chk("R9 done count", n_done, 1);
      chk("R10 pll_en kept", int'(pll_en), 1);
   endtask

   initial begin
      do_reset();
      for (int i = 0; i < NVEC; i++) begin
         if (!VECS[i].chain) do_reset();
         run_vec(VECS[i]);
      end
      // Directed: a start during reset is not taken
      @(negedge clk);
      rst_n = 1'b0; start = 1'b1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1; start = 1'b0;
      repeat (10) @(negedge clk);
      check_reset_state();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule